// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 memory with two chip selects from power-up to operation. It needs no software. A single `start` pulse makes it walk a fixed list of twelve commands on chip select 0. It then walks the same list on chip select 1.

The list covers the following steps, in order:
- precharge-all;
- the three extended mode registers;
- the mode register with the memory DLL reset;
- two auto-refreshes;
- the mode register again with the DLL reset released;
- the off-chip-driver calibration entry and exit.

Between consecutive commands the bus is held deselected for a programmable gap. Once both ranks are set up, `done` rises and stays high. From then on, a refresh timer raises `refresh_req` periodically, using a programmable interval count. A typical interval is 7.8 µs times the clock frequency, for example 1038 cycles at 133 MHz.

The state machine has four states:
- **IDLE**: waits for `start`.
- **ISSUE**: drives one command for one cycle.
- **WAIT**: counts the gap with the bus deselected.
- **DONE**: terminal state with refresh enabled.

Transitions:
- IDLE→ISSUE on `start`.
- ISSUE→WAIT always.
- WAIT→ISSUE when the gap expires and commands remain.
- WAIT→DONE when the gap expires after the twelfth command of the last chip select.
- DONE holds until reset.

Top module: `ddr2_bringup_seq`

## Requirements
- R1: While reset (`rst_n` low) is applied and afterwards until `start`, the outputs are idle: `cs_n` all ones, `ras_n`/`cas_n`/`we_n` high, `ba` and `addr` zero, and `done` and `refresh_req` low.
- R2: A `start` sampled high in IDLE puts the first command on the bus in the next cycle. `start` is ignored in every other state.
- R3: Each chip select receives twelve commands in this order: NOP, PALL, EMRS2, EMRS3, EMRS1, MRS, PALL, REF, REF, MRS, EMRS1, EMRS1. The encodings of {`ras_n`,`cas_n`,`we_n`} are:
  - NOP = 111 (with `ba`/`addr` zero);
  - PALL = 010;
  - REF = 001 (with `ba`/`addr` zero);
  - any mode-register write = 000.
- R4: The mode-register writes carry these `ba` and `addr` values:
  - EMRS2: `ba`=2, `addr`=0;
  - EMRS3: `ba`=3, `addr`=0;
  - the first EMRS1: `ba`=1, `addr`=0x400;
  - the first MRS: `ba`=0, `addr`=0x542 (DLL reset, CL 4, BL 4);
  - the second MRS: `ba`=0, `addr`=0x442;
  - the calibration-default EMRS1: `ba`=1, `addr`=0x780;
  - the final EMRS1: `ba`=1, `addr`=0x400.
- R5: Precharge-all drives `ba`=0 and `addr`=0x400, which is A10 high.
- R6: All twelve commands go to chip select 0 (`cs_n`=2'b10) before any goes to chip select 1 (`cs_n`=2'b01). At most one `cs_n` bit is ever low. 24 commands are issued in total.
- R7: Each command lasts one cycle. The next command issues exactly `gap_cycles`+2 cycles later, with `cs_n` all ones in between.
- R8: `done` rises `gap_cycles`+2 cycles after the last command and stays high until reset.
- R9: `refresh_req` stays low until `done`. Counting the cycle where `done` first reads high as cycle 0, the first one-cycle pulse comes at cycle `refresh_interval`. Later pulses come every `refresh_interval`+1 cycles.
- R10: After `done`, a `start` pulse has no effect: the bus stays deselected and `done` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the initialization sequence |
| gap_cycles | input | GAP_W | Extra idle cycles between commands |
| refresh_interval | input | REF_W | Refresh timer reload count |
| done | output | 1 | Both chip selects initialized |
| refresh_req | output | 1 | One-cycle periodic refresh request |
| cs_n | output | NUM_CS | Active-low chip selects |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 3 | Bank address |
| addr | output | 14 | Address / mode-register field |

## Verification
The bench keeps the default `NUM_CS`=2, `GAP_W`=8 and `REF_W`=16, and runs two bring-ups.

The first run uses a gap of 3 and an interval of 12. The second run uses a gap of 0 and an interval of 5.

The zero gap exercises the shortest ISSUE→WAIT→ISSUE loop, where the timer expires on its first WAIT cycle. The short intervals make two refresh periods observable after `done`, which exposes any off-by-one in the reload.

A `start` pulse injected mid-sequence and another after `done` reach the "ignored" paths.

// File: rtl/ddr2_seq_pkg.sv
package ddr2_seq_pkg;

    localparam int BANK_W  = 3;
    localparam int ADDR_W  = 14;
    localparam int STEPS   = 12;
    localparam int STEP_W  = $clog2(STEPS);

    // mode-register field values
    localparam logic [ADDR_W-1:0] MODE_ZERO     = 14'h000;
    localparam logic [ADDR_W-1:0] EXT_DLL_ON    = 14'h400;
    localparam logic [ADDR_W-1:0] MAIN_DLL_RST  = 14'h542;
    localparam logic [ADDR_W-1:0] MAIN_DLL_RUN  = 14'h442;
    localparam logic [ADDR_W-1:0] EXT_OCD_DFLT  = 14'h780;
    localparam logic [ADDR_W-1:0] PALL_A10      = 14'h400;

    typedef enum logic [1:0] {
        K_NOP,
        K_PALL,
        K_REF,
        K_MODE
    } cmd_kind_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        cmd_kind_t         kind;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] field;
    } init_cmd_t;

endpackage

// File: rtl/ddr2_step_rom.sv
module ddr2_step_rom
    import ddr2_seq_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    output init_cmd_t         cmd
);

    always_comb begin
        cmd = '{kind: K_NOP, bank: '0, field: MODE_ZERO};
        unique case (step)
            4'd0:  cmd = '{kind: K_NOP,  bank: 3'd0, field: MODE_ZERO};
            4'd1:  cmd = '{kind: K_PALL, bank: 3'd0, field: PALL_A10};
            4'd2:  cmd = '{kind: K_MODE, bank: 3'd2, field: MODE_ZERO};
            4'd3:  cmd = '{kind: K_MODE, bank: 3'd3, field: MODE_ZERO};
            4'd4:  cmd = '{kind: K_MODE, bank: 3'd1, field: EXT_DLL_ON};
            4'd5:  cmd = '{kind: K_MODE, bank: 3'd0, field: MAIN_DLL_RST};
            4'd6:  cmd = '{kind: K_PALL, bank: 3'd0, field: PALL_A10};
            4'd7:  cmd = '{kind: K_REF,  bank: 3'd0, field: MODE_ZERO};
            4'd8:  cmd = '{kind: K_REF,  bank: 3'd0, field: MODE_ZERO};
            4'd9:  cmd = '{kind: K_MODE, bank: 3'd0, field: MAIN_DLL_RUN};
            4'd10: cmd = '{kind: K_MODE, bank: 3'd1, field: EXT_OCD_DFLT};
            4'd11: cmd = '{kind: K_MODE, bank: 3'd1, field: EXT_DLL_ON};
            default: cmd = '{kind: K_NOP, bank: 3'd0, field: MODE_ZERO};
        endcase
    end

endmodule

// File: rtl/ddr2_gap_timer.sv
module ddr2_gap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    output logic             expired
);

    logic [GAP_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R7: the gap counts down one per cycle once loaded
    a_r7_gap_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !expired) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/ddr2_refresh_timer.sv
module ddr2_refresh_timer #(
    parameter int REF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [REF_W-1:0] interval,
    output logic             req
);

    logic [REF_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!enable || cnt == '0)
            cnt <= interval;
        else
            cnt <= cnt - 1'b1;
    end

    assign req = enable && (cnt == '0);

    // R9: every request restarts the full interval
    a_r9_reload_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (cnt == $past(interval)));

endmodule

// File: rtl/ddr2_bringup_seq.sv
module ddr2_bringup_seq
    import ddr2_seq_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int GAP_W  = 8,
    parameter int REF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [GAP_W-1:0]  gap_cycles,
    input  logic [REF_W-1:0]  refresh_interval,
    output logic              done,
    output logic              refresh_req,
    output logic [NUM_CS-1:0] cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr
);

    localparam int CHIP_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);
    localparam logic [CHIP_W-1:0] LAST_CHIP = CHIP_W'(NUM_CS - 1);

    seq_state_t        state, state_nx;
    logic [STEP_W-1:0] step;
    logic [CHIP_W-1:0] chip;
    logic              gap_done;
    logic              final_cmd;
    init_cmd_t         cur_cmd;
    logic [NUM_CS-1:0] cs_sel;

    assign final_cmd = (step == LAST_STEP) && (chip == LAST_CHIP);

    ddr2_step_rom u_rom (
        .step (step),
        .cmd  (cur_cmd)
    );

    ddr2_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state == S_ISSUE),
        .load_val (gap_cycles),
        .expired  (gap_done)
    );

    ddr2_refresh_timer #(.REF_W(REF_W)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (state == S_DONE),
        .interval (refresh_interval),
        .req      (refresh_req)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_ISSUE;
            S_ISSUE: state_nx = S_WAIT;
            S_WAIT:  if (gap_done) state_nx = final_cmd ? S_DONE : S_ISSUE;
            S_DONE:  state_nx = S_DONE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register and position in the list
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            step  <= '0;
            chip  <= '0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && start) begin
                step <= '0;
                chip <= '0;
            end else if (state == S_WAIT && gap_done && !final_cmd) begin
                if (step == LAST_STEP) begin
                    step <= '0;
                    chip <= chip + 1'b1;
                end else begin
                    step <= step + 1'b1;
                end
            end
        end
    end

    // chip-select decode
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_sel[g] = (state == S_ISSUE) && (chip == CHIP_W'(g));
    end
    assign cs_n = ~cs_sel;

    // command bus outputs
    always_comb begin
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        ba    = '0;
        addr  = '0;
        done  = (state == S_DONE);
        if (state == S_ISSUE) begin
            ba   = cur_cmd.bank;
            addr = cur_cmd.field;
            unique case (cur_cmd.kind)
                K_NOP:  begin ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; end
                K_PALL: begin ras_n = 1'b0; cas_n = 1'b1; we_n = 1'b0; end
                K_REF:  begin ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b1; end
                K_MODE: begin ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0; end
                default: begin ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; end
            endcase
        end
    end

    // R6: never more than one rank selected
    a_r6_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R7: a command is always followed by a deselected cycle
    a_r7_deselect_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1) |=> (cs_n == '1));

    // R8: done is sticky
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R9: no refresh request before initialization completes
    a_r9_req_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> done);

endmodule

// File: tb/ddr2_bringup_seq_test.sv
module ddr2_bringup_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  gap_cycles = 8'd0;
    logic [15:0] refresh_interval = 16'd0;
    logic        done, refresh_req, ras_n, cas_n, we_n;
    logic [1:0]  cs_n;
    logic [2:0]  ba;
    logic [13:0] addr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ddr2_bringup_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .gap_cycles(gap_cycles), .refresh_interval(refresh_interval),
        .done(done), .refresh_req(refresh_req), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {ras_n,cas_n,we_n,ba,addr} per step, from R3/R4/R5
    function automatic logic [19:0] exp_cmd(input int s);
        case (s)
            0:  return {3'b111, 3'd0, 14'h000};
            1:  return {3'b010, 3'd0, 14'h400};
            2:  return {3'b000, 3'd2, 14'h000};
            3:  return {3'b000, 3'd3, 14'h000};
            4:  return {3'b000, 3'd1, 14'h400};
            5:  return {3'b000, 3'd0, 14'h542};
            6:  return {3'b010, 3'd0, 14'h400};
            7:  return {3'b001, 3'd0, 14'h000};
            8:  return {3'b001, 3'd0, 14'h000};
            9:  return {3'b000, 3'd0, 14'h442};
            10: return {3'b000, 3'd1, 14'h780};
            default: return {3'b000, 3'd1, 14'h400};
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 idle state after reset
        check(cs_n == 2'b11 && {ras_n, cas_n, we_n} == 3'b111 && ba == 3'd0 && addr == 14'd0,
              "R1 bus idle", {cs_n, ras_n, cas_n, we_n, ba, addr}, {2'b11, 3'b111, 17'd0});
        check(!done && !refresh_req, "R1 done/req low", {done, refresh_req}, 0);
    endtask

    task automatic run_bringup(input int gap, input int ival);
        int cyc = 0;
        int idx = 0;
        int last = 0;
        int early = 0;
        int first_req = -1;
        int second_req = -1;
        int nreq = 0;
        bit seen_bad_cs = 0;
        do_reset();
        gap_cycles = 8'(gap);
        refresh_interval = 16'(ival);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done && cyc < 5000) begin
            if (cs_n != 2'b11) begin
                int chip = (cs_n == 2'b10) ? 0 : (cs_n == 2'b01) ? 1 : 9;
                if (chip != idx / 12) seen_bad_cs = 1;
                check(chip == idx / 12, "R6 rank order", chip, idx / 12);
                check({ras_n, cas_n, we_n, ba, addr} == exp_cmd(idx % 12), "R3/R4/R5 command",
                      {ras_n, cas_n, we_n, ba, addr}, exp_cmd(idx % 12));
                if (idx == 0) check(cyc == 0, "R2 first command timing", cyc, 0);
                else          check(cyc - last == gap + 2, "R7 command spacing", cyc - last, gap + 2);
                last = cyc;
                idx++;
            end
            if (refresh_req) early++;
            @(negedge clk);
            // R2: a start pulse in the middle of the run must change nothing
            start = (idx == 5);
            cyc++;
        end
        start = 1'b0;
        check(idx == 24, "R6 command count", idx, 24);
        check(cyc - last == gap + 2, "R8 done delay", cyc - last, gap + 2);
        check(early == 0, "R9 no early request", early, 0);
        // R9 refresh timing; cycle 0 = first done cycle
        for (int k = 0; k <= 2 * ival + 3; k++) begin
            if (refresh_req) begin
                nreq++;
                if (first_req < 0) first_req = k;
                else if (second_req < 0) second_req = k;
            end
            if (!done) early++;
            @(negedge clk);
        end
        check(first_req == ival, "R9 first request", first_req, ival);
        check(second_req == 2 * ival + 1, "R9 second request", second_req, 2 * ival + 1);
        check(nreq == 2, "R9 one-cycle pulses", nreq, 2);
        check(early == 0, "R8 done held", early, 0);
        // R10 start after done is ignored
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        begin
            int bad = 0;
            for (int k = 0; k < 20; k++) begin
                if (cs_n != 2'b11 || !done) bad++;
                @(negedge clk);
            end
            check(bad == 0, "R10 start ignored after done", bad, 0);
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        run_bringup(3, 12);
        run_bringup(0, 5);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule